// File: doc/BRIEF.md
# Tagged Store Unit with Auto-Offset

This block is the store datapath of a small sequencer that writes into a memory of 32-bit words. Each command carries 16-bit register operands: a base register value together with its 2-bit index, a source value, a byte offset, a 2-bit label, and the word address of the store instruction. The unit turns one command into one write on its memory port. That write has a word address, 32 bits of data and four byte-lane enables. The word address is the base value plus the byte offset divided by four.

Five store variants are supported:

- A tagged full-word store places a provenance tag above the source value. The tag is built from the instruction address and the base register index.
- A lower-half store and an upper-half store each write the source value into one 16-bit half of the word.
- A half-word auto-increment store and a 32-bit tagged auto-increment store take their offset from an internal register instead of the command.

A separate set-offset command preloads that internal register. The half-word variant fills the lower half of a word and then its upper half, and only then moves on by one word. The 32-bit variant moves on by one word after every store.

Every write appears on the port registered, one clock after the command is accepted.

Top module: `tagged_store_unit`

## Requirements
- R1: After reset `wr_en` is 0, `wr_be` is 0, `wr_addr` and `wr_data` are 0, the internal offset is 0 and the half selector points at the lower half.
- R2: For opcodes 1, 2 and 3, `wr_addr` is `(base_val + (offset >> 2))` taken modulo 2^ADDR_W.
- R3: Opcode 1 (tagged word) writes `{pc[10:0], 3'b000, base_idx, src_val}` with `wr_be` = 4'b1111.
- R4: Opcode 2 (lower half) writes with `wr_be` = 4'b0011, and opcode 3 (upper half) writes with `wr_be` = 4'b1100. For both, `wr_data` = `{src_val, src_val}`.
- R5: Opcode 4 (set offset) produces no write. It loads the internal offset with `offset` and points the half selector at the lower half.
- R6: Opcode 5 (auto half) writes to `base_val + (internal_offset >> 2)` with `wr_data` = `{src_val, src_val}`. It uses `wr_be` 4'b0011 when the selector is on the lower half and 4'b1100 when it is on the upper half. The selector then toggles, and the internal offset grows by 4 only after an upper-half store.
- R7: Opcode 6 (auto tagged word) writes `{pc[10:0], 3'b000, label, src_val}` with `wr_be` = 4'b1111 to `base_val + (internal_offset >> 2)`. The internal offset then grows by 4 and the half selector is left unchanged.
- R8: Opcode 0, opcode 7, or `cmd_valid` low produces no write (`wr_en` 0, `wr_be` 0) and leaves the internal offset and the half selector unchanged.
- R9: The write for a command accepted at a rising edge appears on the port for exactly the following clock cycle.
- R10: The internal offset is 16 bits wide and wraps modulo 2^16 when it is incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Store variant opcode (0 none, 1 tagged word, 2 low half, 3 high half, 4 set offset, 5 auto half, 6 auto tagged word, 7 none) |
| base_idx | input | 2 | Index of the base register, placed in the tag |
| base_val | input | 16 | Base register value, in words |
| src_val | input | 16 | Value to store |
| offset | input | 16 | Byte offset, or the value to load for set offset |
| label | input | 2 | Label placed in the auto tagged word |
| pc | input | 11 | Word address of the store instruction |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte-lane enables |

## Verification
A long random mix of all eight opcodes, with `cmd_valid` sometimes low, is compared cycle by cycle against a reference model. Because set-offset commands land between runs of auto stores at random, this mix separates a selector that resets on set-offset from one that keeps stale state. Directed sequences check the following cases:

- Four auto half stores in a row, which tell lower-before-upper ordering apart from the reverse and show that the offset advances after the second store, not the first.
- Back-to-back auto tagged words, which confirm that every store advances the offset and that the selector is left alone.
- A base near the top of the address range and an offset of 0xFFFC, which expose wrap handling.
- Byte offsets with nonzero low bits, which show that those bits are dropped.

// File: rtl/tagged_store_unit.sv
module tagged_store_unit #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        base_idx,
  input  logic [15:0]       base_val,
  input  logic [15:0]       src_val,
  input  logic [15:0]       offset,
  input  logic [1:0]        label,
  input  logic [10:0]       pc,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be
);
  localparam logic [2:0] OP_TAG  = 3'd1;
  localparam logic [2:0] OP_LO   = 3'd2;
  localparam logic [2:0] OP_HI   = 3'd3;
  localparam logic [2:0] OP_SETO = 3'd4;
  localparam logic [2:0] OP_AH   = 3'd5;
  localparam logic [2:0] OP_AT   = 3'd6;
  localparam logic [3:0] BE_LO   = 4'b0011;
  localparam logic [3:0] BE_HI   = 4'b1100;
  localparam logic [3:0] BE_ALL  = 4'b1111;

  logic [15:0] auto_ofs;
  logic        hi_sel;

  logic        is_auto;
  logic [15:0] eff_ofs;
  logic [15:0] addr_sum;

  assign is_auto  = (cmd_op == OP_AH) || (cmd_op == OP_AT);
  assign eff_ofs  = is_auto ? auto_ofs : offset;
  assign addr_sum = base_val + (eff_ofs >> 2);

  logic        n_en;
  logic [31:0] n_data;
  logic [3:0]  n_be;

  always_comb begin
    n_en   = 1'b0;
    n_be   = 4'b0000;
    n_data = {src_val, src_val};
    if (cmd_valid) begin
      case (cmd_op)
        OP_TAG: begin
          n_en   = 1'b1;
          n_be   = BE_ALL;
          n_data = {pc, 3'b000, base_idx, src_val};
        end
        OP_LO: begin
          n_en = 1'b1;
          n_be = BE_LO;
        end
        OP_HI: begin
          n_en = 1'b1;
          n_be = BE_HI;
        end
        OP_AH: begin
          n_en = 1'b1;
          n_be = hi_sel ? BE_HI : BE_LO;
        end
        OP_AT: begin
          n_en   = 1'b1;
          n_be   = BE_ALL;
          n_data = {pc, 3'b000, label, src_val};
        end
        default: n_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_ofs <= '0;
      hi_sel   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else begin
      wr_en <= n_en;
      wr_be <= n_be;
      if (n_en) begin
        wr_addr <= addr_sum[ADDR_W-1:0];
        wr_data <= n_data;
      end
      if (cmd_valid) begin
        case (cmd_op)
          OP_SETO: begin
            auto_ofs <= offset;
            hi_sel   <= 1'b0;
          end
          OP_AH: begin
            hi_sel <= ~hi_sel;
            if (hi_sel) auto_ofs <= auto_ofs + 16'd4;
          end
          OP_AT: auto_ofs <= auto_ofs + 16'd4;
          default: ;
        endcase
      end
    end
  end
endmodule

module tagged_store_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [1:0]        base_idx,
  input logic [15:0]       src_val,
  input logic [10:0]       pc,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [3:0]        wr_be
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !wr_en && wr_be == 4'b0000); // R1
  AST_TAG_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> wr_en && wr_be == 4'b1111 &&
      wr_data == {$past(pc), 3'b000, $past(base_idx), $past(src_val)}); // R3
  AST_LO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> wr_en && wr_be == 4'b0011 && wr_data[15:0] == $past(src_val)); // R4
  AST_HI_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> wr_en && wr_be == 4'b1100 && wr_data[31:16] == $past(src_val)); // R4
  AST_SETOFS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> !wr_en); // R5
  AST_HALF_AUTO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> wr_en && (wr_be == 4'b0011 || wr_be == 4'b1100)); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 3'd0 || cmd_op == 3'd7) |=> !wr_en && wr_be == 4'b0000); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> $stable(wr_addr)); // R9
endmodule

bind tagged_store_unit tagged_store_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .base_idx(base_idx), .src_val(src_val), .pc(pc), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
);

// File: tb/tagged_store_unit_bench.sv
module tagged_store_unit_bench;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] base_idx = 0, label = 0;
  logic [15:0] base_val = 0, src_val = 0, offset = 0;
  logic [10:0] pc = 0;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_be;

  int checks = 0, failures = 0;
  logic [15:0] m_ofs = 0;
  logic m_hi = 0;
  logic [AW-1:0] m_addr = 0;
  logic [31:0] m_data = 0;

  always #5 clk = ~clk;

  tagged_store_unit #(.ADDR_W(AW)) u_tagged_store_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .base_idx(base_idx), .base_val(base_val), .src_val(src_val),
    .offset(offset), .label(label), .pc(pc), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input logic [15:0] b, input logic [15:0] o);
    return b + (o >> 2);
  endfunction

  // Present one command on a negedge, update the model, sample the result on the next negedge.
  task automatic step(input string req, input logic v, input logic [2:0] op, input logic [1:0] bi,
                      input logic [15:0] bv, input logic [15:0] sv, input logic [15:0] of,
                      input logic [1:0] lb, input logic [10:0] p);
    logic e_en;
    logic [3:0] e_be;
    cmd_valid = v; cmd_op = op; base_idx = bi; base_val = bv;
    src_val = sv; offset = of; label = lb; pc = p;
    e_en = 0; e_be = 0;
    if (v) begin
      case (op)
        3'd1: begin e_en = 1; e_be = 4'hF; m_addr = addr_of(bv, of); m_data = {p, 3'b0, bi, sv}; end
        3'd2: begin e_en = 1; e_be = 4'h3; m_addr = addr_of(bv, of); m_data = {sv, sv}; end
        3'd3: begin e_en = 1; e_be = 4'hC; m_addr = addr_of(bv, of); m_data = {sv, sv}; end
        3'd4: begin m_ofs = of; m_hi = 0; end
        3'd5: begin
          e_en = 1; e_be = m_hi ? 4'hC : 4'h3; m_addr = addr_of(bv, m_ofs); m_data = {sv, sv};
          if (m_hi) m_ofs = m_ofs + 16'd4;
          m_hi = ~m_hi;
        end
        3'd6: begin
          e_en = 1; e_be = 4'hF; m_addr = addr_of(bv, m_ofs); m_data = {p, 3'b0, lb, sv};
          m_ofs = m_ofs + 16'd4;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check({req, " en"}, 64'(wr_en), 64'(e_en));
    check({req, " be"}, 64'(wr_be), 64'(e_be));
    if (e_en) begin
      check({req, " addr"}, 64'(wr_addr), 64'(m_addr));
      check({req, " data"}, 64'(wr_data), 64'(m_data));
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 en", 64'(wr_en), 0);
    check("R1 be", 64'(wr_be), 0);
    check("R1 addr", 64'(wr_addr), 0);
    check("R1 data", 64'(wr_data), 0);
    rst_n = 1;
    // R1: offset 0 and lower half right after reset
    step("R1 auto after reset", 1, 3'd5, 0, 16'h0100, 16'hAAAA, 0, 0, 11'd1);
    step("R1 auto after reset 2", 1, 3'd5, 0, 16'h0100, 16'hBBBB, 0, 0, 11'd2);
    // R2 R3 with nonzero low offset bits
    step("R3 tag", 1, 3'd1, 2'd3, 16'h0010, 16'h1234, 16'h0007, 0, 11'h7FF);
    step("R2 tag wrap", 1, 3'd1, 2'd1, 16'hFFFF, 16'h5555, 16'h0008, 0, 11'h123);
    step("R4 lo", 1, 3'd2, 0, 16'h0020, 16'hBEEF, 16'h0004, 0, 0);
    step("R4 hi", 1, 3'd3, 0, 16'h0020, 16'hCAFE, 16'h0004, 0, 0);
    // R5 R6: set offset then four half auto stores
    step("R5 setofs", 1, 3'd4, 0, 0, 0, 16'h0010, 0, 0);
    for (int i = 0; i < 4; i++)
      step("R6 auto half", 1, 3'd5, 2'd2, 16'h0200, 16'(i + 16'h0A00), 16'hFFFF, 0, 11'(i));
    // R5: set offset mid-pair resets selector
    step("R6 auto half lo", 1, 3'd5, 0, 16'h0300, 16'h0001, 0, 0, 0);
    step("R5 setofs mid", 1, 3'd4, 0, 0, 0, 16'h0040, 0, 0);
    step("R5 after setofs lo", 1, 3'd5, 0, 16'h0300, 16'h0002, 0, 0, 0);
    // R7: tagged auto, selector kept
    step("R7 auto tag", 1, 3'd6, 0, 16'h0300, 16'h7777, 0, 2'd2, 11'h055);
    step("R7 auto tag 2", 1, 3'd6, 0, 16'h0300, 16'h8888, 0, 2'd1, 11'h056);
    step("R7 selector kept", 1, 3'd5, 0, 16'h0300, 16'h9999, 0, 0, 0);
    // R8: idle opcodes and invalid cycles
    step("R8 op0", 1, 3'd0, 0, 16'h1, 16'h1, 16'h1, 0, 0);
    step("R8 op7", 1, 3'd7, 0, 16'h1, 16'h1, 16'h1, 0, 0);
    step("R8 invalid setofs", 0, 3'd4, 0, 0, 0, 16'h0800, 0, 0);
    step("R8 state kept", 1, 3'd5, 0, 16'h0300, 16'h4444, 0, 0, 0);
    // R10: wrap of the internal offset
    step("R10 setofs", 1, 3'd4, 0, 0, 0, 16'hFFFC, 0, 0);
    step("R10 tag at top", 1, 3'd6, 0, 16'h0005, 16'h1111, 0, 2'd3, 11'd9);
    step("R10 tag wrapped", 1, 3'd6, 0, 16'h0005, 16'h2222, 0, 2'd0, 11'd10);
    // R9 random mix, checked every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op;
      logic [15:0] of;
      op = 3'($urandom_range(0, 7));
      of = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 64));
      step("R9 random", ($urandom_range(0, 7) != 0), op, 2'($urandom), 16'($urandom),
           16'($urandom), of, 2'($urandom), 11'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule